// File: doc/BRIEF.md
# Serial Receive Buffer with Interrupt Sources

This block sits behind a serial-line deserializer and holds the characters it delivers until software or a DMA engine collects them. Each complete character arrives as a one-cycle strobe that carries the data byte and three per-character condition flags: a bad stop bit, a parity mismatch and a break. An enabled receiver writes the character into a first-in first-out store of `DEPTH` entries. The oldest entry is always visible on the read port, and a pop request removes it.

Three interrupt sources are derived from the store.
- **Level:** the stored count has reached a programmable threshold.
- **Error:** a sticky error flag is set. The flags record overrun, framing, parity and break conditions and are cleared by writing ones.
- **Idle timeout:** characters are waiting but nothing has been pushed or popped for four character times. One character time is ten baud ticks.

Each source has its own enable bit. The single interrupt line is the OR of the enabled sources. A clear input empties the store and resets all receive status in one cycle.

Top module: `serial_rx_buffer`

## Requirements
- R1: After reset the store is empty: `fifoCount` is 0, `dataAvail` is 0, `errFlags` is 0, the timeout status is 0 and `irq` is 0.
- R2: When `rxEnable` is 1, a `charValid` strobe that finds the store not full writes `charData`. While `dataAvail` is 1, `popData` shows the oldest stored byte. `popReq` removes that byte one cycle later, and the order of arrival is kept.
- R3: A strobe that arrives while `DEPTH` entries are held is discarded, and the stored contents are unchanged. It sets the overrun flag, `errFlags` bit 0. This holds even if a pop happens in the same cycle.
- R4: While `rxEnable` is 0, strobes are ignored. They store nothing and set no error flag.
- R5: `irqStatus` bit 0 (level) is 1 exactly when `fifoCount >= trigLevel`. A trigger level of 0 keeps it set at all times.
- R6: An accepted strobe sets sticky flags from its condition bits: `errFlags` bit 1 from `charFrameErr`, bit 2 from `charParityErr` and bit 3 from `charBreak`.
  - A flag stays set until a 1 is written to the same bit of `errClear`. If a new error and a clear land on the same bit in the same cycle, the flag stays set.
  - `irqStatus` bit 1 (error) is the OR of the four flags.
- R7: `irqStatus` bit 2 (timeout) becomes 1 after 40 `baudTick` pulses have been counted with the store non-empty and no push or pop in between. Every push or pop restarts the count. The bit is never 1 while the store is empty.
- R8: `fifoClear` empties the store, clears `errFlags` and the timeout count, and takes priority over a push, a pop or a new error in the same cycle.
- R9: `irq` is the OR of the `irqStatus` bits masked by `irqEnable`: bit 0 enables level, bit 1 enables error and bit 2 enables timeout.
- R10: A `popReq` while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Receiver enable; strobes are ignored when 0 |
| charValid | input | 1 | One-cycle strobe for a received character |
| charData | input | 8 | Received character |
| charFrameErr | input | 1 | Bad stop bit seen on this character |
| charParityErr | input | 1 | Parity mismatch on this character |
| charBreak | input | 1 | Break condition seen on this character |
| baudTick | input | 1 | One pulse per bit period |
| popReq | input | 1 | Remove the oldest entry |
| fifoClear | input | 1 | Empty the store and clear receive status |
| errClear | input | 4 | Write-one-to-clear for the error flags |
| irqEnable | input | 3 | Per-source interrupt enables {timeout, error, level} |
| trigLevel | input | 5 | Level-interrupt threshold |
| dataAvail | output | 1 | Store not empty |
| popData | output | 8 | Oldest stored byte |
| fifoCount | output | 5 | Number of stored entries |
| irqStatus | output | 3 | Raw sources {timeout, error, level} |
| errFlags | output | 4 | Sticky flags {break, parity, frame, overrun} |
| irq | output | 1 | Interrupt request |

## Verification
The two conditions that are hardest to reach from the ports are the idle timeout and the overrun.
- **Timeout:** it needs 40 baud ticks in a row with no push or pop while data is held. The random phases therefore include stretches with rare pops and frequent ticks, and a directed sequence stores one byte and checks the status after exactly 39 ticks and again after 40.
- **Overrun:** it needs a completely full store. A directed burst of seventeen back-to-back strobes with no pops reaches it, and a further strobe is sent together with a pop at the full boundary.

A reference model in the bench follows every cycle, so the random phases also compare clears, error-clear collisions and threshold changes against the requirements.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  // Strobes from control to datapath, at most one action per kind per cycle
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCtl_t;

  localparam int SRC_LEVEL   = 0;
  localparam int SRC_ERROR   = 1;
  localparam int SRC_TIMEOUT = 2;
  localparam int NUM_SRC     = 3;

  localparam int ERR_OVERRUN = 0;
  localparam int ERR_FRAME   = 1;
  localparam int ERR_PARITY  = 2;
  localparam int ERR_BREAK   = 3;
  localparam int NUM_ERR     = 4;
endpackage

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (ctl.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/serial_rx_control.sv
module serial_rx_control
  import serial_rx_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int CNT_W         = $clog2(DEPTH + 1),
  parameter int TRIG_W        = 5,
  parameter int CHAR_BITS     = 10,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxEnable,
  input  logic               charValid,
  input  logic               charFrameErr,
  input  logic               charParityErr,
  input  logic               charBreak,
  input  logic               baudTick,
  input  logic               popReq,
  input  logic               fifoClear,
  input  logic [NUM_ERR-1:0] errClear,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic [TRIG_W-1:0]  trigLevel,
  input  logic [CNT_W-1:0]   count,
  input  logic               empty,
  input  logic               full,
  output fifoCtl_t           ctl,
  output logic [NUM_SRC-1:0] irqStatus,
  output logic [NUM_ERR-1:0] errFlags,
  output logic               irq
);
  localparam int LIMIT = CHAR_BITS * TIMEOUT_CHARS;
  localparam int TMR_W = $clog2(LIMIT + 1);
  localparam int CMP_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W;

  logic               accept;
  logic [NUM_ERR-1:0] errSet;
  logic [TMR_W-1:0]   idleTmr;

  assign accept = rxEnable && charValid;

  always_comb begin
    ctl.clear = fifoClear;
    ctl.push  = accept && !full && !fifoClear;
    ctl.pop   = popReq && !empty && !fifoClear;
    errSet              = '0;
    errSet[ERR_OVERRUN] = accept && full;
    errSet[ERR_FRAME]   = accept && charFrameErr;
    errSet[ERR_PARITY]  = accept && charParityErr;
    errSet[ERR_BREAK]   = accept && charBreak;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errFlags <= '0;
    else if (fifoClear) errFlags <= '0;
    else                errFlags <= (errFlags & ~errClear) | errSet;
  end

  // Idle timer: counts baud ticks while data waits untouched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      idleTmr <= '0;
    else if (fifoClear || ctl.push || ctl.pop || empty)
      idleTmr <= '0;
    else if (baudTick && idleTmr != TMR_W'(LIMIT))
      idleTmr <= idleTmr + 1'b1;
  end

  always_comb begin
    irqStatus              = '0;
    irqStatus[SRC_LEVEL]   = CMP_W'(count) >= CMP_W'(trigLevel);
    irqStatus[SRC_ERROR]   = |errFlags;
    irqStatus[SRC_TIMEOUT] = (idleTmr == TMR_W'(LIMIT)) && !empty;
    irq                    = |(irqStatus & irqEnable);
  end
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import serial_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int TRIG_W = 5,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxEnable,
  input  logic               charValid,
  input  logic [DATA_W-1:0]  charData,
  input  logic               charFrameErr,
  input  logic               charParityErr,
  input  logic               charBreak,
  input  logic               baudTick,
  input  logic               popReq,
  input  logic               fifoClear,
  input  logic [NUM_ERR-1:0] errClear,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic [TRIG_W-1:0]  trigLevel,
  output logic               dataAvail,
  output logic [DATA_W-1:0]  popData,
  output logic [CNT_W-1:0]   fifoCount,
  output logic [NUM_SRC-1:0] irqStatus,
  output logic [NUM_ERR-1:0] errFlags,
  output logic               irq
);
  fifoCtl_t ctl;
  logic     empty, full;

  serial_rx_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(charData),
    .rdData(popData), .count(fifoCount), .empty(empty), .full(full)
  );

  serial_rx_control #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_ctl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .charValid(charValid),
    .charFrameErr(charFrameErr), .charParityErr(charParityErr), .charBreak(charBreak),
    .baudTick(baudTick), .popReq(popReq), .fifoClear(fifoClear), .errClear(errClear),
    .irqEnable(irqEnable), .trigLevel(trigLevel), .count(fifoCount), .empty(empty),
    .full(full), .ctl(ctl), .irqStatus(irqStatus), .errFlags(errFlags), .irq(irq)
  );

  assign dataAvail = !empty;
endmodule

// File: rtl/serial_rx_buffer_chk.sv
module serial_rx_buffer_chk #(
  parameter int DEPTH  = 16,
  parameter int TRIG_W = 5,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              charValid,
  input logic              popReq,
  input logic              fifoClear,
  input logic [3:0]        errClear,
  input logic [2:0]        irqEnable,
  input logic [TRIG_W-1:0] trigLevel,
  input logic              dataAvail,
  input logic [CNT_W-1:0]  fifoCount,
  input logic [2:0]        irqStatus,
  input logic [3:0]        errFlags,
  input logic              irq
);
  localparam logic [CNT_W-1:0] FULLCNT = CNT_W'(DEPTH);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= FULLCNT);

  p_overrun_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && charValid && fifoCount == FULLCNT && !fifoClear |=> errFlags[0]);

  p_overrun_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && charValid && fifoCount == FULLCNT && !fifoClear && !popReq
    |=> fifoCount == FULLCNT);

  p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable && !popReq && !fifoClear |=> $stable(fifoCount));

  p_level_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    trigLevel == '0 |-> irqStatus[0]);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    errFlags[1] && !errClear[1] && !fifoClear |=> errFlags[1]);

  p_timeout_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqStatus[2] |-> dataAvail);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> fifoCount == '0 && errFlags == '0 && !irqStatus[2]);

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqEnable == '0 |-> !irq);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dataAvail && popReq && !charValid |=> fifoCount == '0);
endmodule

bind serial_rx_buffer serial_rx_buffer_chk #(.DEPTH(DEPTH), .TRIG_W(TRIG_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_serial_rx_buffer.sv
`timescale 1ns/1ps
module sim_serial_rx_buffer;
  localparam int DEPTH = 16;
  localparam int LIMIT = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxEnable, charValid, charFrameErr, charParityErr, charBreak, baudTick;
  logic popReq, fifoClear;
  logic [7:0] charData;
  logic [3:0] errClear;
  logic [2:0] irqEnable;
  logic [4:0] trigLevel;
  logic dataAvail, irq;
  logic [7:0] popData;
  logic [4:0] fifoCount;
  logic [2:0] irqStatus;
  logic [3:0] errFlags;

  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  serial_rx_buffer u0 (.*);

  // Reference model, built from the requirements
  logic [7:0] mq[$];
  logic [3:0] me;
  int tq, sz;
  bit acc, doPush, doPop;

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete(); me = '0; tq = 0;
    end else begin
      acc = rxEnable && charValid;
      sz  = mq.size();
      if (fifoClear) begin
        mq.delete(); me = '0; tq = 0;
      end else begin
        doPop  = popReq && sz > 0;
        doPush = acc && sz < DEPTH;
        me = (me & ~errClear) |
             {charBreak & acc, charParityErr & acc, charFrameErr & acc, acc && sz == DEPTH};
        if (doPush || doPop || sz == 0) tq = 0;
        else if (baudTick && tq < LIMIT) tq++;
        if (doPop)  void'(mq.pop_front());
        if (doPush) mq.push_back(charData);
      end
    end
  end

  function automatic logic [2:0] expStatus(input int n, input logic [3:0] e, input int t,
                                           input logic [4:0] trig);
    return {(t == LIMIT) && n > 0, |e, n >= int'(trig)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [2:0] st;
    st = expStatus(mq.size(), me, tq, trigLevel);
    check("R2 fifoCount", 32'(fifoCount), 32'(mq.size()));
    check("R2 dataAvail", 32'(dataAvail), 32'(mq.size() > 0));
    if (mq.size() > 0) check("R2 popData", 32'(popData), 32'(mq[0]));
    check("R5 level", 32'(irqStatus[0]), 32'(st[0]));
    check("R6 errFlags", 32'(errFlags), 32'(me));
    check("R6 errStatus", 32'(irqStatus[1]), 32'(st[1]));
    check("R7 timeout", 32'(irqStatus[2]), 32'(st[2]));
    check("R9 irq", 32'(irq), 32'(|(st & irqEnable)));
  endtask

  task automatic step();
    @(negedge clk);
    checkAll();
  endtask

  task automatic idle();
    rxEnable = 1'b1; charValid = 1'b0; charData = '0; charFrameErr = 1'b0;
    charParityErr = 1'b0; charBreak = 1'b0; baudTick = 1'b0; popReq = 1'b0;
    fifoClear = 1'b0; errClear = '0;
  endtask

  task automatic push(input logic [7:0] d);
    charValid = 1'b1; charData = d;
    step();
    charValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); irqEnable = 3'b000; trigLevel = 5'd1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R1 reset state
    check("R1 count", 32'(fifoCount), 0);
    check("R1 dataAvail", 32'(dataAvail), 0);
    check("R1 errFlags", 32'(errFlags), 0);
    check("R1 irq", 32'(irq), 0);

    // R10 pop on empty
    popReq = 1'b1; step(); popReq = 1'b0;
    check("R10 count after empty pop", 32'(fifoCount), 0);

    // R3 fill past full
    for (int i = 0; i < DEPTH + 1; i++) push(8'(8'h40 + i));
    check("R3 count held at full", 32'(fifoCount), DEPTH);
    check("R3 overrun flag", 32'(errFlags[0]), 1);
    check("R3 head kept", 32'(popData), 32'h40);
    charValid = 1'b1; charData = 8'hEE; popReq = 1'b1; step();
    charValid = 1'b0; popReq = 1'b0;
    check("R3 full with pop drops", 32'(fifoCount), DEPTH - 1);
    // R9 masking
    irqEnable = 3'b000; step();
    check("R9 masked", 32'(irq), 0);
    irqEnable = 3'b010; step();
    check("R9 error enabled", 32'(irq), 1);
    errClear = 4'b0001; step(); errClear = '0;
    check("R6 w1c overrun", 32'(errFlags), 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      check("R2 drain order", 32'(popData), 32'(8'h41 + i));
      popReq = 1'b1; step(); popReq = 1'b0;
    end

    // R4 disabled receiver
    rxEnable = 1'b0; charValid = 1'b1; charBreak = 1'b1; charFrameErr = 1'b1;
    step(); step();
    idle();
    check("R4 nothing stored", 32'(fifoCount), 0);
    check("R4 no flags", 32'(errFlags), 0);

    // R7 timeout window
    trigLevel = 5'd9; irqEnable = 3'b100;
    baudTick = 1'b1; repeat (50) step();
    check("R7 empty never times out", 32'(irqStatus[2]), 0);
    baudTick = 1'b0;
    push(8'hA5);
    baudTick = 1'b1;
    repeat (LIMIT - 1) step();
    check("R7 not yet at 39", 32'(irqStatus[2]), 0);
    step();
    check("R7 fires at 40", 32'(irqStatus[2]), 1);
    check("R9 timeout irq", 32'(irq), 1);
    popReq = 1'b1; step(); popReq = 1'b0;
    check("R7 pop restarts", 32'(irqStatus[2]), 0);
    baudTick = 1'b0;

    // R8 clear has priority
    push(8'h11); push(8'h22);
    fifoClear = 1'b1; charValid = 1'b1; charParityErr = 1'b1; popReq = 1'b1; step();
    idle();
    check("R8 cleared count", 32'(fifoCount), 0);
    check("R8 cleared flags", 32'(errFlags), 0);

    // R5 zero threshold
    trigLevel = 5'd0; step();
    check("R5 zero threshold", 32'(irqStatus[0]), 1);

    // Random phases with varied weights
    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        rxEnable      = ($urandom % 16) != 0;
        charValid     = ($urandom % 4) < (ph == 1 ? 3 : 1);
        charData      = 8'($urandom);
        charFrameErr  = ($urandom % 16) == 0;
        charParityErr = ($urandom % 16) == 0;
        charBreak     = ($urandom % 32) == 0;
        baudTick      = ($urandom % 2) == 0;
        popReq        = ($urandom % 8) < (ph == 2 ? 1 : (ph == 3 ? 0 : 3));
        if (ph == 3) charValid = ($urandom % 64) == 0;
        fifoClear     = ($urandom % 300) == 0;
        errClear      = (($urandom % 20) == 0) ? 4'($urandom) : 4'b0;
        if (($urandom % 50) == 0) irqEnable = 3'($urandom);
        if (($urandom % 50) == 0) trigLevel = 5'($urandom % 20);
        step();
      end
    end
    idle();
    step();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule